// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital controller that times a successive-approximation conversion. It produces no analog result. It only counts the time a conversion takes. A start strobe captures the configuration. The block may then wait for an asynchronous clock source to warm up. It then spends a fixed number of bus cycles and a number of conversion-clock (ADCK) ticks in a first-conversion overhead phase. After that it runs one base conversion per averaged sample. At the end it pulses a completion flag for one bus cycle.

ADCK is not a separate clock. It is a one-cycle enable derived from a selected tick source, then divided by 1, 2, 4 or 8. When the last result of a run completes, the block snapshots the bus cycles and ADCK ticks that result used, so the timing can be checked at the ports.

In continuous mode the next result starts at once, with no overhead phase. A stop strobe or a configuration-write strobe aborts the run. Every pin is a plain control or status signal. The block carries no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, `busy` and `done` are 0, and `bus_cycles` and `adck_cycles` read 0.
- R2: The ADCK ticks per base conversion depend on `mode`:
  - code 0 takes 17 ticks;
  - code 1 takes 27 ticks;
  - codes 2 and 4 take 20 ticks;
  - codes 3, 5, 6 and 7 take 30 ticks.
- R3: With `avg_en`=0, one base conversion makes a result. With `avg_en`=1, `avg_sel` values 0, 1, 2 and 3 give 4, 8, 16 and 32 base conversions.
- R4: The first result of a run adds an overhead before its base conversions: exactly 5 bus cycles, then 3 ADCK ticks when `long_smp`=1 or 5 when `long_smp`=0.
- R5: If `clk_sel`=3 at start and `async_en` has not been 1 for at least WAIT_CYC consecutive bus cycles, a wait of WAIT_CYC bus cycles comes before the overhead. WAIT_CYC = BUS_FREQ_HZ/1e6 × STARTUP_US, which is 40 by default. Otherwise there is no wait.
- R6: Each ADCK tick takes s×d bus cycles. The source factor s is 1 for `clk_sel`=0 and 2 for `clk_sel`=1. For `clk_sel`=2 a source tick is `alt_tick`, and for `clk_sel`=3 it is `async_tick`. The divide d is 2^`div_sel`. The divider restarts when the ADCK phase begins.
- R7: `done` is high for exactly one cycle, at the end of the cycle in which the last tick of the last base conversion occurs. At the same edge:
  - `bus_cycles` takes the number of non-idle cycles that result used;
  - `adck_cycles` takes its ADCK ticks.
  - For a first result, `done` is seen bus_cycles+1 edges after the edge that samples `start`.
- R8: With `cont`=1, each later result starts right after `done` and skips the wait and the overhead. Each later result reports base-conversion time only.
- R9: Abort and start-while-busy rules:
  - A `stop` or `cfg_wr` strobe while busy returns the block to idle on the next edge, with no `done`, and leaves the reported counts unchanged.
  - A `start` while busy is ignored.
  - An abort strobe in the same cycle as `start` suppresses the start.
- R10: The configuration is captured at start. Later changes of the configuration inputs, without `cfg_wr`, do not affect the running result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe |
| stop | input | 1 | Abort strobe |
| cfg_wr | input | 1 | Configuration-write strobe, aborts when busy |
| mode | input | 3 | Resolution and input-type code |
| long_smp | input | 1 | Long sample enable |
| avg_en | input | 1 | Averaging enable |
| avg_sel | input | 2 | Averaging count select |
| clk_sel | input | 2 | Tick source select |
| div_sel | input | 2 | Divide ratio select |
| cont | input | 1 | Continuous conversion enable |
| async_en | input | 1 | Asynchronous source enable |
| alt_tick | input | 1 | Alternate source tick |
| async_tick | input | 1 | Asynchronous source tick |
| busy | output | 1 | Sequence running |
| done | output | 1 | One-cycle completion pulse |
| bus_cycles | output | CNT_W | Bus cycles used by the last result |
| adck_cycles | output | CNT_W | ADCK ticks used by the last result |

## Verification
A wrong phase counter, sample counter or divider state shows up when the result completes. Either `done` arrives at the wrong edge, or one of the two snapshot counts differs from what the formulas give, and the two counts together tell which term is wrong. A stuck state instead shows as `busy` staying high, or as no `done` within the expected window. A bad abort path shows on the edge right after the strobe, because `busy` does not drop, or a stale `done` appears later.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WARM,
    S_BUS,
    S_OVH,
    S_CONV
  } seq_st_e;

  typedef struct packed {
    logic [2:0] mode;
    logic       long_smp;
    logic       avg_en;
    logic [1:0] avg_sel;
    logic [1:0] clk_sel;
    logic [1:0] div_sel;
    logic       cont;
  } seq_cfg_t;

  localparam int BUS_OVH_CYC = 5;

  // ADCK ticks per base conversion, by mode code
  function automatic logic [4:0] base_ticks(input logic [2:0] m);
    case (m)
      3'd0:         return 5'd17;
      3'd1:         return 5'd27;
      3'd2, 3'd4:   return 5'd20;
      default:      return 5'd30;
    endcase
  endfunction

  // number of base conversions per result
  function automatic logic [5:0] sample_count(input logic en, input logic [1:0] sel);
    if (!en) return 6'd1;
    return 6'd4 << sel;
  endfunction

  // ADCK ticks of first-conversion overhead
  function automatic logic [2:0] ovh_ticks(input logic long_en);
    return long_en ? 3'd3 : 3'd5;
  endfunction

endpackage

// File: rtl/adc_ck_div.sv
module adc_ck_div #(
  parameter int DIV_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] clk_sel,
  input  logic [1:0] div_sel,
  input  logic       alt_tick,
  input  logic       async_tick,
  output logic       adck_tk
);

  logic [DIV_W-1:0] dcnt;
  logic [DIV_W-1:0] lim;
  logic             half;
  logic             src_tk;

  always_comb begin
    case (clk_sel)
      2'b00:   src_tk = 1'b1;
      2'b01:   src_tk = half;
      2'b10:   src_tk = alt_tick;
      default: src_tk = async_tick;
    endcase
  end

  assign lim     = DIV_W'((4'd1 << div_sel) - 4'd1);
  assign adck_tk = run && src_tk && (dcnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0;
      half <= 1'b0;
    end else if (!run) begin
      dcnt <= '0;
      half <= 1'b0;
    end else begin
      half <= ~half;
      if (src_tk) dcnt <= (dcnt == lim) ? '0 : dcnt + DIV_W'(1);
    end
  end

  AST_HALF_NO_BACK2BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (adck_tk && clk_sel == 2'b01) |=> !adck_tk); // R6

endmodule

// File: rtl/adc_warm_trk.sv
module adc_warm_trk #(
  parameter int WAIT_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_en,
  output logic warm
);

  localparam int WW = $clog2(WAIT_CYC + 1);

  logic [WW-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    held <= '0;
    else if (!async_en)            held <= '0;
    else if (held != WW'(WAIT_CYC)) held <= held + WW'(1);
  end

  assign warm = (held == WW'(WAIT_CYC));

  AST_WARM_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !async_en |=> !warm); // R5

endmodule

// File: rtl/adc_seq_ctl.sv
module adc_seq_ctl
  import adc_seq_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int WAIT_CYC = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             cfg_wr,
  input  seq_cfg_t         cfg_in,
  input  logic             warm,
  input  logic             adck_tk,
  output logic             run,
  output logic [1:0]       clk_sel_q,
  output logic [1:0]       div_sel_q,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] bus_cycles,
  output logic [CNT_W-1:0] adck_cycles
);

  localparam int PH_W = $clog2(WAIT_CYC + 32);

  seq_st_e          st;
  seq_cfg_t         cfg_q;
  logic [PH_W-1:0]  ph;
  logic [5:0]       smp;
  logic [CNT_W-1:0] acc_b, acc_a;
  logic             abort;

  assign abort     = stop || cfg_wr;
  assign run       = (st == S_OVH) || (st == S_CONV);
  assign busy      = (st != S_IDLE);
  assign clk_sel_q = cfg_q.clk_sel;
  assign div_sel_q = cfg_q.div_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cfg_q       <= '0;
      ph          <= '0;
      smp         <= '0;
      acc_b       <= '0;
      acc_a       <= '0;
      done        <= 1'b0;
      bus_cycles  <= '0;
      adck_cycles <= '0;
    end else begin
      done <= 1'b0;
      if (st != S_IDLE) begin
        acc_b <= acc_b + CNT_W'(1);
        if (adck_tk) acc_a <= acc_a + CNT_W'(1);
      end
      if (abort) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            cfg_q <= cfg_in;
            acc_b <= '0;
            acc_a <= '0;
            if (cfg_in.clk_sel == 2'b11 && !warm) begin
              st <= S_WARM;
              ph <= PH_W'(WAIT_CYC - 1);
            end else begin
              st <= S_BUS;
              ph <= PH_W'(BUS_OVH_CYC - 1);
            end
          end
          S_WARM: begin
            if (ph == '0) begin
              st <= S_BUS;
              ph <= PH_W'(BUS_OVH_CYC - 1);
            end else ph <= ph - PH_W'(1);
          end
          S_BUS: begin
            if (ph == '0) begin
              st <= S_OVH;
              ph <= PH_W'(ovh_ticks(cfg_q.long_smp) - 3'd1);
            end else ph <= ph - PH_W'(1);
          end
          S_OVH: if (adck_tk) begin
            if (ph == '0) begin
              st  <= S_CONV;
              ph  <= PH_W'(base_ticks(cfg_q.mode) - 5'd1);
              smp <= sample_count(cfg_q.avg_en, cfg_q.avg_sel) - 6'd1;
            end else ph <= ph - PH_W'(1);
          end
          S_CONV: if (adck_tk) begin
            if (ph != '0) begin
              ph <= ph - PH_W'(1);
            end else if (smp != '0) begin
              smp <= smp - 6'd1;
              ph  <= PH_W'(base_ticks(cfg_q.mode) - 5'd1);
            end else begin
              done        <= 1'b1;
              bus_cycles  <= acc_b + CNT_W'(1);
              adck_cycles <= acc_a + CNT_W'(1);
              if (cfg_q.cont) begin
                ph    <= PH_W'(base_ticks(cfg_q.mode) - 5'd1);
                smp   <= sample_count(cfg_q.avg_en, cfg_q.avg_sel) - 6'd1;
                acc_b <= '0;
                acc_a <= '0;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_AFTER_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(st) == S_CONV)); // R7
  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort) |=> !busy); // R9
  AST_BUS_NOT_BELOW_ADCK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bus_cycles >= adck_cycles)); // R6
  AST_BASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CONV) |-> (ph < PH_W'(30))); // R2
  AST_SAMPLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CONV) |-> (smp < 6'd32)); // R3

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int BUS_FREQ_HZ = 8_000_000,
  parameter int STARTUP_US  = 5,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             cfg_wr,
  input  logic [2:0]       mode,
  input  logic             long_smp,
  input  logic             avg_en,
  input  logic [1:0]       avg_sel,
  input  logic [1:0]       clk_sel,
  input  logic [1:0]       div_sel,
  input  logic             cont,
  input  logic             async_en,
  input  logic             alt_tick,
  input  logic             async_tick,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] bus_cycles,
  output logic [CNT_W-1:0] adck_cycles
);

  localparam int RAW_WAIT = (BUS_FREQ_HZ / 1_000_000) * STARTUP_US;
  localparam int WAIT_CYC = (RAW_WAIT < 1) ? 1 : RAW_WAIT;

  seq_cfg_t   cfg_in;
  logic       warm, adck_tk, run;
  logic [1:0] clk_sel_q, div_sel_q;

  assign cfg_in = '{mode: mode, long_smp: long_smp, avg_en: avg_en,
                    avg_sel: avg_sel, clk_sel: clk_sel, div_sel: div_sel,
                    cont: cont};

  adc_warm_trk #(.WAIT_CYC(WAIT_CYC)) u_warm (
    .clk(clk), .rst_n(rst_n), .async_en(async_en), .warm(warm)
  );

  adc_ck_div #(.DIV_W(3)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .clk_sel(clk_sel_q),
    .div_sel(div_sel_q), .alt_tick(alt_tick), .async_tick(async_tick),
    .adck_tk(adck_tk)
  );

  adc_seq_ctl #(.CNT_W(CNT_W), .WAIT_CYC(WAIT_CYC)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .cfg_wr(cfg_wr),
    .cfg_in(cfg_in), .warm(warm), .adck_tk(adck_tk), .run(run),
    .clk_sel_q(clk_sel_q), .div_sel_q(div_sel_q), .busy(busy), .done(done),
    .bus_cycles(bus_cycles), .adck_cycles(adck_cycles)
  );

endmodule

// File: tb/test_adc_conv_seq.sv
module test_adc_conv_seq;

  localparam int CLK_PERIOD = 10;
  localparam int WAIT_CYC   = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, stop = 0, cfg_wr = 0;
  logic [2:0] mode = 0;
  logic long_smp = 0, avg_en = 0, cont = 0, async_en = 0;
  logic [1:0] avg_sel = 0, clk_sel = 0, div_sel = 0;
  logic alt_tick = 1, async_tick = 1;
  logic busy, done;
  logic [15:0] bus_cycles, adck_cycles;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_conv_seq i_adc_conv_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .cfg_wr(cfg_wr),
    .mode(mode), .long_smp(long_smp), .avg_en(avg_en), .avg_sel(avg_sel),
    .clk_sel(clk_sel), .div_sel(div_sel), .cont(cont), .async_en(async_en),
    .alt_tick(alt_tick), .async_tick(async_tick), .busy(busy), .done(done),
    .bus_cycles(bus_cycles), .adck_cycles(adck_cycles)
  );

  // {mode, long_smp, avg_en, avg_sel, clk_sel, div_sel, exp_bus, exp_adck}
  localparam logic [42:0] VEC [8] = '{
    {3'd0, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 16'd25,   16'd20},
    {3'd1, 1'b0, 1'b1, 2'd0, 2'd0, 2'd1, 16'd231,  16'd113},
    {3'd2, 1'b1, 1'b1, 2'd1, 2'd1, 2'd0, 16'd331,  16'd163},
    {3'd3, 1'b0, 1'b0, 2'd0, 2'd0, 2'd2, 16'd145,  16'd35},
    {3'd4, 1'b0, 1'b1, 2'd2, 2'd0, 2'd3, 16'd2605, 16'd325},
    {3'd5, 1'b1, 1'b1, 2'd3, 2'd0, 2'd0, 16'd968,  16'd963},
    {3'd0, 1'b1, 1'b0, 2'd0, 2'd3, 2'd0, 16'd65,   16'd20},
    {3'd6, 1'b0, 1'b0, 2'd0, 2'd2, 2'd0, 16'd40,   16'd35}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply_cfg(input logic [42:0] v);
    mode = v[42:40]; long_smp = v[39]; avg_en = v[38];
    avg_sel = v[37:36]; clk_sel = v[35:34]; div_sel = v[33:32];
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 20000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic count_dones(input int cycles, output int seen);
    seen = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (done) seen++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL R7 watchdog: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat, seen;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 counts", int'(bus_cycles) + int'(adck_cycles), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R6 R7: table walk
    for (int i = 0; i < 8; i++) begin
      apply_cfg(VEC[i]);
      pulse_start();
      wait_done(lat);
      check($sformatf("R7 latency v%0d", i), lat, int'(VEC[i][31:16]) + 1);
      check($sformatf("R2/R3/R4/R6 bus v%0d", i), int'(bus_cycles), int'(VEC[i][31:16]));
      check($sformatf("R2/R3/R4 adck v%0d", i), int'(adck_cycles), int'(VEC[i][15:0]));
      @(negedge clk);
      check($sformatf("R7 pulse width v%0d", i), int'(done), 0);
      check($sformatf("R7 idle after v%0d", i), int'(busy), 0);
    end

    // R5: warm asynchronous source skips the startup wait
    async_en = 1'b1;
    repeat (WAIT_CYC + 5) @(negedge clk);
    apply_cfg(VEC[6]);
    pulse_start();
    wait_done(lat);
    check("R5 warm bus", int'(bus_cycles), 25);
    check("R5 warm latency", lat, 26);
    async_en = 1'b0;
    @(negedge clk);

    // R8: continuous mode
    apply_cfg(VEC[0]);
    cont = 1'b1;
    pulse_start();
    wait_done(lat);
    check("R8 first bus", int'(bus_cycles), 25);
    @(negedge clk);
    check("R7 cont pulse width", int'(done), 0);
    wait_done(lat);
    check("R8 next latency", lat, 17);
    check("R8 next bus", int'(bus_cycles), 17);
    check("R8 next adck", int'(adck_cycles), 17);
    cont = 1'b0;

    // R9: stop aborts continuous run
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check("R9 stop idle", int'(busy), 0);
    count_dones(40, seen);
    check("R9 stop no done", seen, 0);

    // R9: cfg_wr aborts mid-run, counts unchanged
    apply_cfg(VEC[5]);
    pulse_start();
    repeat (10) @(negedge clk);
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    check("R9 cfg_wr idle", int'(busy), 0);
    check("R9 counts kept", int'(bus_cycles), 17);
    count_dones(40, seen);
    check("R9 cfg_wr no done", seen, 0);

    // R9: start while busy is ignored
    apply_cfg(VEC[3]);
    pulse_start();
    repeat (20) @(negedge clk);
    pulse_start();
    wait_done(lat);
    check("R9 restart ignored latency", lat, 145 - 21 + 1);
    check("R9 restart ignored bus", int'(bus_cycles), 145);
    @(negedge clk);

    // R9: abort with start in same cycle suppresses start
    cfg_wr = 1'b1;
    pulse_start();
    cfg_wr = 1'b0;
    check("R9 start suppressed", int'(busy), 0);

    // R10: inputs changed mid-run have no effect
    apply_cfg(VEC[0]);
    pulse_start();
    mode = 3'd5; avg_en = 1'b1; avg_sel = 2'd3; long_smp = 1'b0; div_sel = 2'd3;
    wait_done(lat);
    check("R10 bus", int'(bus_cycles), 25);
    check("R10 adck", int'(adck_cycles), 20);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule